// File: doc/BRIEF.md
# Fixed-Probability Binary Range Encoder

This block turns a serial stream of bits into a byte stream by range coding. Every bit is coded with one constant probability of one half, so no model memory is kept between bits. The coder state is a 32-bit interval width, a 33-bit lower edge and one held-back output byte. The held-back byte, together with a counter of deferred 0xFF bytes, lets a carry out of the lower edge reach bytes that have already been decided but not yet sent.

After reset the block first sends a fixed header of thirteen bytes: one configuration byte, a 32-bit dictionary size and a 64-bit uncompressed size. It then waits in standby for input tokens offered with a valid/ready handshake. A token is either a data bit or an end-of-stream command. Whenever the interval width falls below 2^24, the block rescales the interval and may send bytes. The end-of-stream command pushes the remaining bytes of the lower edge out through the cache, and the block then stays done until the next reset. Output bytes appear as single-cycle strobes, one byte per cycle at most.

Top module: `rc_range_encoder`

## Requirements
- R1: After reset the block sends 13 header bytes on consecutive cycles, least significant byte first within each field. The bytes are the configuration byte, then the dictionary size as 4 bytes, then the uncompressed size as 8 bytes. in_ready stays low until the last header byte has been sent.
- R2: In standby, in_ready is high and out_valid stays low for as long as no token is offered.
- R3: A data bit is coded with bound = (range >> 11) * 1024. A 0 sets range to bound and leaves low unchanged. A 1 adds bound to low and sets range to range - bound. Range starts at 0xFFFFFFFF and low starts at 0.
- R4: While range < 2^24 the block performs shift steps. Each step shifts range left by 8, keeps bits 23:0 of low and moves them up by 8. Standby is only re-entered once range >= 2^24.
- R5: In a shift step, if low >= 2^32 or bits 31:24 of low are not 0xFF, the block sends the cache plus bit 32 of low, modulo 256. It then sends each deferred byte as (0xFF + that carry) modulo 256 and loads the cache with bits 31:24 of low. Otherwise it adds one to the count of deferred bytes and sends nothing.
- R6: The cache starts at 0x00, so the first coded byte after the header is the cache value plus carry.
- R7: A token with in_flush = 1 is a command, and its in_bit is ignored. It runs exactly five shift steps without changing range, then done rises and stays high with in_ready low until reset.
- R8: in_ready is low while shift steps run or deferred bytes are being sent. At most one byte is sent per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A token is offered |
| in_ready | output | 1 | Block is in standby and takes the token this cycle |
| in_bit | input | 1 | Data bit of the token |
| in_flush | input | 1 | Token is the end-of-stream command |
| out_valid | output | 1 | out_byte holds a new output byte this cycle |
| out_byte | output | 8 | Output byte |
| done | output | 1 | End-of-stream processing finished |

## Verification
The assertions assume that a token is only taken while in_ready is high. They also assume that in_bit and in_flush are meaningful only with in_valid, and that nobody offers further tokens after the end-of-stream command. The bench drives tokens at the falling edge, and only after it has seen in_ready high. It inserts random idle gaps between tokens and sends exactly one end-of-stream command per stream, with a random in_bit. Between streams it resets the block, so the done state is never left by any other means.

// File: rtl/rcenc_pkg.sv
package rcenc_pkg;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_IDLE,
    ST_SHIFT,
    ST_DRAIN,
    ST_DONE
  } rc_state_e;

  // byte plus carry, wrapping modulo 256
  function automatic logic [7:0] byte_add_carry(input logic [7:0] b, input logic c);
    return b + {7'd0, c};
  endfunction

endpackage

// File: rtl/rcenc_hdr_gen.sv
module rcenc_hdr_gen #(
  parameter logic [7:0] CFG_BYTE  = 8'h5D,
  parameter int         DICT_W    = 32,
  parameter logic [DICT_W-1:0] DICT_SIZE = 32'h0010_0000,
  parameter int         RAW_W     = 64,
  parameter logic [RAW_W-1:0] RAW_SIZE = 64'h0000_0000_0000_0400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance_i,
  output logic [7:0] byte_o,
  output logic       last_o
);
  localparam int HDR_BYTES = 1 + DICT_W / 8 + RAW_W / 8;
  localparam int IDX_W     = $clog2(HDR_BYTES);
  localparam logic [8*HDR_BYTES-1:0] HDR_VEC = {RAW_SIZE, DICT_SIZE, CFG_BYTE};

  logic [7:0]       hdr_arr [HDR_BYTES];
  logic [IDX_W-1:0] idx_q;

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hdr_arr[g] = HDR_VEC[8*g +: 8];
  end

  assign last_o = (idx_q == IDX_W'(HDR_BYTES - 1));
  assign byte_o = hdr_arr[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idx_q <= '0;
    else if (advance_i && !last_o) idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/rcenc_bit_coder.sv
module rcenc_bit_coder #(
  parameter int RANGE_W   = 32,
  parameter int PROB_BITS = 11,
  parameter int PROB      = 1024
) (
  input  logic [RANGE_W-1:0] range_i,
  input  logic [RANGE_W:0]   low_i,
  input  logic               bit_i,
  output logic [RANGE_W-1:0] range_o,
  output logic [RANGE_W:0]   low_o
);
  localparam logic [RANGE_W-1:0] PROB_V = RANGE_W'(PROB);

  logic [RANGE_W-1:0] bound;

  always_comb begin
    bound = (range_i >> PROB_BITS) * PROB_V;
    if (bit_i) begin
      range_o = range_i - bound;
      low_o   = low_i + {1'b0, bound};
    end else begin
      range_o = bound;
      low_o   = low_i;
    end
  end
endmodule

// File: rtl/rcenc_shift_unit.sv
module rcenc_shift_unit #(
  parameter int RANGE_W = 32
) (
  input  logic [RANGE_W:0] low_i,
  output logic             release_o,
  output logic             carry_o,
  output logic [7:0]       top_byte_o,
  output logic [RANGE_W:0] low_next_o
);
  assign carry_o    = low_i[RANGE_W];
  assign top_byte_o = low_i[RANGE_W-1 -: 8];
  assign release_o  = carry_o || (top_byte_o != 8'hFF);
  assign low_next_o = {1'b0, low_i[RANGE_W-9:0], 8'h00};
endmodule

// File: rtl/rc_range_encoder.sv
module rc_range_encoder #(
  parameter int         RANGE_W      = 32,
  parameter int         PROB_BITS    = 11,
  parameter int         PROB         = 1024,
  parameter int         FLUSH_SHIFTS = 5,
  parameter int         PEND_W       = 16,
  parameter logic [7:0] CFG_BYTE     = 8'h5D,
  parameter int         DICT_W       = 32,
  parameter logic [DICT_W-1:0] DICT_SIZE = 32'h0010_0000,
  parameter int         RAW_W        = 64,
  parameter logic [RAW_W-1:0] RAW_SIZE = 64'h0000_0000_0000_0400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_flush,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       done
);
  import rcenc_pkg::*;

  localparam int FC_W = $clog2(FLUSH_SHIFTS + 1);
  localparam logic [RANGE_W-1:0] TOP_LIM = RANGE_W'(1) << (RANGE_W - 8);

  rc_state_e          state_q;
  logic [RANGE_W-1:0] range_q;
  logic [RANGE_W:0]   low_q;
  logic [7:0]         cache_q;
  logic [PEND_W-1:0]  pend_q;
  logic               carry_q;
  logic               flushing_q;
  logic [FC_W-1:0]    flush_cnt_q;
  logic               out_valid_q;
  logic [7:0]         out_byte_q;

  // named events for the checker
  logic               hdr_active, accept_bit, accept_flush, need_shift;
  logic               shift_ev, release_ev, drain_ev;

  logic [7:0]         hdr_byte;
  logic               hdr_last;
  logic [RANGE_W-1:0] coded_range;
  logic [RANGE_W:0]   coded_low, shifted_low;
  logic               sh_release, sh_carry;
  logic [7:0]         sh_top;

  assign hdr_active   = (state_q == ST_HDR);
  assign in_ready     = (state_q == ST_IDLE);
  assign accept_bit   = in_ready && in_valid && !in_flush;
  assign accept_flush = in_ready && in_valid && in_flush;
  assign need_shift   = flushing_q ? (flush_cnt_q != '0) : (range_q < TOP_LIM);
  assign shift_ev     = (state_q == ST_SHIFT) && need_shift;
  assign release_ev   = shift_ev && sh_release;
  assign drain_ev     = (state_q == ST_DRAIN);

  rcenc_hdr_gen #(
    .CFG_BYTE(CFG_BYTE), .DICT_W(DICT_W), .DICT_SIZE(DICT_SIZE),
    .RAW_W(RAW_W), .RAW_SIZE(RAW_SIZE)
  ) hdr_i (
    .clk(clk), .rst_n(rst_n), .advance_i(hdr_active),
    .byte_o(hdr_byte), .last_o(hdr_last)
  );

  rcenc_bit_coder #(.RANGE_W(RANGE_W), .PROB_BITS(PROB_BITS), .PROB(PROB)) coder_i (
    .range_i(range_q), .low_i(low_q), .bit_i(in_bit),
    .range_o(coded_range), .low_o(coded_low)
  );

  rcenc_shift_unit #(.RANGE_W(RANGE_W)) shift_i (
    .low_i(low_q), .release_o(sh_release), .carry_o(sh_carry),
    .top_byte_o(sh_top), .low_next_o(shifted_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HDR;
      range_q     <= '1;
      low_q       <= '0;
      cache_q     <= 8'h00;
      pend_q      <= '0;
      carry_q     <= 1'b0;
      flushing_q  <= 1'b0;
      flush_cnt_q <= '0;
      out_valid_q <= 1'b0;
      out_byte_q  <= 8'h00;
    end else begin
      out_valid_q <= 1'b0;
      unique case (state_q)
        ST_HDR: begin
          out_valid_q <= 1'b1;
          out_byte_q  <= hdr_byte;
          if (hdr_last) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept_flush) begin
            flushing_q  <= 1'b1;
            flush_cnt_q <= FC_W'(FLUSH_SHIFTS);
            state_q     <= ST_SHIFT;
          end else if (accept_bit) begin
            range_q <= coded_range;
            low_q   <= coded_low;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (!need_shift) begin
            state_q <= flushing_q ? ST_DONE : ST_IDLE;
          end else begin
            low_q <= shifted_low;
            if (flushing_q) flush_cnt_q <= flush_cnt_q - 1'b1;
            else            range_q     <= range_q << 8;
            if (sh_release) begin
              out_valid_q <= 1'b1;
              out_byte_q  <= byte_add_carry(cache_q, sh_carry);
              carry_q     <= sh_carry;
              cache_q     <= sh_top;
              if (pend_q != '0) state_q <= ST_DRAIN;
            end else begin
              pend_q <= pend_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          out_valid_q <= 1'b1;
          out_byte_q  <= byte_add_carry(8'hFF, carry_q);
          pend_q      <= pend_q - 1'b1;
          if (pend_q == PEND_W'(1)) state_q <= ST_SHIFT;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign out_valid = out_valid_q;
  assign out_byte  = out_byte_q;
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/rcenc_checker.sv
module rcenc_checker #(
  parameter int RANGE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_bit,
  input logic               in_flush,
  input logic               out_valid,
  input logic               done,
  input logic               hdr_active,
  input logic               drain_ev,
  input logic [RANGE_W-1:0] range_q,
  input logic [RANGE_W:0]   low_q
);
  localparam logic [RANGE_W-1:0] TOP_LIM = RANGE_W'(1) << (RANGE_W - 8);

  assert_hdr_blocks_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_active |-> !in_ready);

  assert_standby_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !out_valid);

  assert_zero_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_flush && !in_bit) |=> $stable(low_q));

  assert_standby_normalized_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (range_q >= TOP_LIM));

  assert_drain_sends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ev |=> out_valid);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready));

  assert_drain_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ev |-> !in_ready);
endmodule

bind rc_range_encoder rcenc_checker #(.RANGE_W(RANGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bit(in_bit), .in_flush(in_flush), .out_valid(out_valid), .done(done),
  .hdr_active(hdr_active), .drain_ev(drain_ev), .range_q(range_q), .low_q(low_q)
);

// File: tb/rc_range_encoder_tb_top.sv
module rc_range_encoder_tb_top;
  localparam logic [7:0]  CFG  = 8'hA7;
  localparam logic [31:0] DICT = 32'h0040_1200;
  localparam logic [63:0] RAW  = 64'h0102_0304_0506_0708;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_flush = 1'b0;
  logic in_ready, out_valid, done;
  logic [7:0] out_byte;

  int checks = 0, errors = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  // reference coder state
  longint unsigned m_low;
  int unsigned     m_range;
  logic [7:0]      m_cache;
  int              m_csize;

  always #5 clk = ~clk;

  rc_range_encoder #(.CFG_BYTE(CFG), .DICT_SIZE(DICT), .RAW_SIZE(RAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_flush(in_flush), .out_valid(out_valid),
    .out_byte(out_byte), .done(done)
  );

  always @(negedge clk) if (rst_n && out_valid) got_q.push_back(out_byte);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_shift();
    logic [7:0] tmp;
    logic [7:0] cy;
    if (m_low < 64'hFF00_0000 || m_low > 64'hFFFF_FFFF) begin
      cy  = 8'(m_low >> 32);
      tmp = m_cache;
      do begin
        exp_q.push_back(tmp + cy);
        tmp = 8'hFF;
        m_csize--;
      end while (m_csize != 0);
      m_cache = 8'(m_low >> 24);
    end
    m_csize++;
    m_low = (m_low & 64'h00FF_FFFF) << 8;
  endtask

  task automatic m_code(input bit b);
    int unsigned bound;
    bound = (m_range >> 11) * 1024;
    if (b) begin m_low += bound; m_range -= bound; end
    else   m_range = bound;
    while (m_range < 32'h0100_0000) begin
      m_range <<= 8;
      m_shift();
    end
  endtask

  task automatic send(input bit b, input bit fl);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_flush = fl;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_bit = $urandom_range(0, 1); in_flush = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  // mode: 0 random, 1 all zero, 2 all one, 3 mostly one
  task automatic run_stream(input int n, input int mode);
    logic [103:0] hv;
    int sz, w;
    bit b;
    got_q.delete(); exp_q.delete();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!out_valid && !in_ready && !done, "R1 reset state", {out_valid, in_ready, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready, "R8 in_ready low in header", in_ready, 0);
    hv = {RAW, DICT, CFG};
    for (int i = 0; i < 13; i++) exp_q.push_back(hv[8*i +: 8]);
    m_low = 0; m_range = 32'hFFFF_FFFF; m_cache = 8'h00; m_csize = 1;
    // standby with nothing offered
    repeat (20) @(negedge clk);
    sz = got_q.size();
    check(sz == 13, "R1 header length", sz, 13);
    for (int i = 0; i < 13 && i < sz; i++)
      check(got_q[i] == exp_q[i], "R1 header byte", got_q[i], exp_q[i]);
    repeat (15) @(negedge clk);
    check(got_q.size() == sz && in_ready, "R2 standby silent", got_q.size(), sz);
    for (int i = 0; i < n; i++) begin
      case (mode)
        1: b = 1'b0;
        2: b = 1'b1;
        3: b = ($urandom_range(0, 7) != 0);
        default: b = $urandom_range(0, 1);
      endcase
      m_code(b);
      send(b, 1'b0);
    end
    send($urandom_range(0, 1), 1'b1);
    for (int i = 0; i < 5; i++) m_shift();
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    check(done && !in_ready, "R7 done sticky, input closed", {done, in_ready}, 2);
    check(got_q.size() == exp_q.size(), "R4 R7 output length", got_q.size(), exp_q.size());
    if (got_q.size() > 13)
      check(got_q[13] == exp_q[13], "R6 first coded byte", got_q[13], exp_q[13]);
    for (int i = 13; i < got_q.size() && i < exp_q.size(); i++)
      check(got_q[i] == exp_q[i], "R3 R5 coded byte", got_q[i], exp_q[i]);
  endtask

  initial begin
    void'($urandom(32'h1234_5A5A));
    run_stream(0, 0);     // header plus flush only
    run_stream(40, 1);    // zeros: range shrinks fast
    run_stream(60, 2);    // ones: low climbs, deferred 0xFF bytes
    run_stream(500, 0);   // random, carries expected
    run_stream(500, 3);   // biased
    run_stream(300, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule